// File: doc/BRIEF.md
# Virtual-Channel Receive Buffer

This block sits at the receiving end of one physical link that carries several virtual channels (VCs). Every VC owns a small private elastic queue. All queues see the same incoming data bus, and each VC has its own valid and ready pair. A flit is stored only in the queue whose valid line is high. Because each queue drops its ready only when it is completely full, a VC that stalls never blocks the others.

On the read side, a round-robin arbiter looks at the VCs that hold at least one flit and whose downstream ready is high. It picks one of them, and a multiplexer presents that VC's oldest flit together with the VC number. The default queue depth is two entries, which is enough for lossless transfer at one flit per cycle over a single-cycle link. The depth is a parameter, so a deeper queue per VC can be built for longer round trips.

Top module: `vc_rx_buffer`

## Requirements
- R1: After a synchronous reset every bit of `in_ready` is 1 and `out_valid` is 0.
- R2: A flit on `in_data` is stored only in the queue of the VC whose `in_valid` bit is set, and only when that VC's `in_ready` bit is also 1. At most one `in_valid` bit is set per cycle.
- R3: Each VC holds up to DEPTH flits. Its `in_ready` bit is 0 exactly when it holds DEPTH flits. A write offered while `in_ready` is 0 is discarded.
- R4: A full VC has no effect on the `in_ready` bits of the other VCs.
- R5: `out_valid` is 1 exactly when at least one VC is nonempty and has its `out_ready` bit set. `out_data` is then the oldest flit of VC `out_vc`.
- R6: A flit leaves its queue only in a cycle where `out_valid` is 1 and `out_ready[out_vc]` is 1.
- R7: Arbitration is round robin. After VC k is served, the next grant goes to the first eligible VC among k+1, k+2, and so on, wrapping around. After reset, VC 0 has the highest priority.
- R8: Within each VC, flits leave in the order they were accepted, and none is lost or duplicated.
- R9: A single VC that is written every cycle and drained every cycle keeps `in_ready` high and sustains one flit per cycle.
- R10: When a VC is written and read in the same cycle, its occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_VC | Per-VC write strobe, at most one bit set |
| in_data | input | DATA_W | Shared write data bus |
| in_ready | output | NUM_VC | Per-VC space available |
| out_ready | input | NUM_VC | Per-VC downstream ready |
| out_valid | output | 1 | A selected flit is presented |
| out_data | output | DATA_W | Flit of the selected VC |
| out_vc | output | max(1, clog2(NUM_VC)) | Number of the selected VC |

## Verification
The bench targets writes to a full VC. A design that overwrote a slot there would show a wrong flit or an extra flit in that VC's scoreboard. It also checks that filling one VC leaves the ready bits of the other VCs untouched; a shared ready would stall them. During round-robin drains, the bench confirms that the grant moves past the VC just served and skips VCs whose downstream ready is low. A fixed-priority or stuck pointer would repeat a VC, and it would show up as a wrong `out_vc`. Streaming with a write and a read on the same VC in every cycle exposes occupancy that drifts or a ready that drops, either of which would halve throughput.

// File: rtl/vcbuf_pkg.sv
package vcbuf_pkg;
  // Width of an index that can name n items (at least one bit).
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vc_fifo.sv
module vc_fifo #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned PTR_W = vcbuf_pkg::idx_width(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  count;
  logic              wr_fire;

  assign wr_ready = (count != FULL_CNT);
  assign rd_valid = (count != '0);
  assign wr_fire  = wr_valid & wr_ready;
  assign rd_data  = mem[rptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_fire) wptr <= (wptr == LAST_SLOT) ? '0 : wptr + 1'b1;
      if (rd_en)   rptr <= (rptr == LAST_SLOT) ? '0 : rptr + 1'b1;
      case ({wr_fire, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> rd_valid);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
  assert_occupancy_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && rd_en) |=> $stable(count));
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int unsigned N = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [N-1:0]                        req,
  input  logic                                advance,
  output logic [N-1:0]                        grant,
  output logic [vcbuf_pkg::idx_width(N)-1:0]  grant_idx
);
  localparam int unsigned IDX_W = vcbuf_pkg::idx_width(N);

  logic [IDX_W-1:0] last_q;

  always_comb begin
    int  idx;
    logic found;
    grant     = '0;
    grant_idx = '0;
    found     = 1'b0;
    idx       = 0;
    for (int k = 1; k <= int'(N); k++) begin
      idx = (int'(last_q) + k) % int'(N);
      if (!found && req[idx]) begin
        grant[idx] = 1'b1;
        grant_idx  = IDX_W'(idx);
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          last_q <= IDX_W'(N - 1);
    else if (advance) last_q <= grant_idx;
  end

  assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  assert_grant_eligible_R5: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0);
  assert_grant_when_req_R5: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> (|grant));
endmodule

// File: rtl/vc_rx_buffer.sv
module vc_rx_buffer #(
  parameter int unsigned NUM_VC = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 2
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [NUM_VC-1:0]                       in_valid,
  input  logic [DATA_W-1:0]                       in_data,
  output logic [NUM_VC-1:0]                       in_ready,
  input  logic [NUM_VC-1:0]                       out_ready,
  output logic                                    out_valid,
  output logic [DATA_W-1:0]                       out_data,
  output logic [vcbuf_pkg::idx_width(NUM_VC)-1:0] out_vc
);
  localparam int unsigned VC_W = vcbuf_pkg::idx_width(NUM_VC);

  logic [NUM_VC-1:0] head_valid;
  logic [NUM_VC-1:0] req;
  logic [NUM_VC-1:0] grant;
  logic [DATA_W-1:0] head_data [NUM_VC];
  logic [VC_W-1:0]   sel;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    vc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .wr_valid (in_valid[v]),
      .wr_data  (in_data),
      .wr_ready (in_ready[v]),
      .rd_en    (grant[v]),
      .rd_valid (head_valid[v]),
      .rd_data  (head_data[v])
    );
  end

  assign req = head_valid & out_ready;

  rr_arbiter #(.N(NUM_VC)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .advance   (out_valid),
    .grant     (grant),
    .grant_idx (sel)
  );

  assign out_valid = |grant;
  assign out_vc    = sel;
  assign out_data  = head_data[sel];

  assert_fire_needs_ready_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_ready[out_vc]);
  assert_single_writer_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_valid));
  assert_ready_after_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> (&in_ready && !out_valid));
endmodule

// File: tb/vc_rx_buffer_bench.sv
module vc_rx_buffer_bench;
  localparam int NV = 3;
  localparam int DW = 16;
  localparam int DP = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NV-1:0] in_valid = '0;
  logic [DW-1:0] in_data = '0;
  logic [NV-1:0] in_ready;
  logic [NV-1:0] out_ready = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic [1:0]    out_vc;

  vc_rx_buffer #(.NUM_VC(NV), .DATA_W(DW), .DEPTH(DP)) u_vc_rx_buffer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_vc(out_vc)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  int q    [NV][16];
  int head [NV];
  int tail [NV];
  int cnt  [NV];
  int last_vc = NV - 1;
  int next_val = 1;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [NV-1:0] vin, input logic [NV-1:0] ordy, input string rtag);
    logic [NV-1:0] exp_rdy;
    int ev;
    @(negedge clk);
    in_valid  = vin;
    in_data   = DW'(next_val);
    out_ready = ordy;
    #2;
    ev = -1;
    for (int i = 0; i < NV; i++) exp_rdy[i] = (cnt[i] < DP);
    for (int k = 1; k <= NV; k++) begin
      int c;
      c = (last_vc + k) % NV;
      if (ev < 0 && cnt[c] > 0 && ordy[c]) ev = c;
    end
    check({rtag, " in_ready"}, int'(in_ready), int'(exp_rdy));
    check("R5 out_valid", int'(out_valid), (ev >= 0) ? 1 : 0);
    if (ev >= 0) begin
      check("R7 out_vc", int'(out_vc), ev);
      check("R8 R6 out_data", int'(out_data), q[ev][head[ev] % 16]);
      head[ev]++; cnt[ev]--; last_vc = ev;
    end
    for (int i = 0; i < NV; i++) begin
      if (vin[i] && exp_rdy[i]) begin
        q[i][tail[i] % 16] = next_val; tail[i]++; cnt[i]++;
      end
    end
    if (vin != '0) next_val++;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NV; i++) begin head[i] = 0; tail[i] = 0; cnt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #2;
    check("R1 in_ready", int'(in_ready), 7);
    check("R1 out_valid", int'(out_valid), 0);

    // R3: overfill VC0 with no drain; R4: others stay ready
    for (int n = 0; n < 4; n++) step(3'b001, 3'b000, "R3 R4");
    // fill VC1 and VC2 too
    for (int n = 0; n < 2; n++) step(3'b010, 3'b000, "R2");
    for (int n = 0; n < 3; n++) step(3'b100, 3'b000, "R3");
    // R7: round-robin drain of all VCs
    for (int n = 0; n < 7; n++) step(3'b000, 3'b111, "R7");
    // R7: skip VCs whose downstream ready is low
    for (int n = 0; n < 2; n++) begin
      step(3'b001, 3'b000, "R2"); step(3'b010, 3'b000, "R2"); step(3'b100, 3'b000, "R2");
    end
    for (int n = 0; n < 3; n++) step(3'b000, 3'b101, "R7");
    for (int n = 0; n < 4; n++) step(3'b000, 3'b111, "R7");
    // R9/R10: streaming on each VC alone
    for (int v = 0; v < NV; v++)
      for (int n = 0; n < 20; n++) step(NV'(1 << v), NV'(1 << v), "R9 R10");
    for (int n = 0; n < 3; n++) step(3'b000, 3'b111, "R8");
    // near-exhaustive sweep over write/ready patterns
    for (int n = 0; n < 3000; n++) begin
      logic [NV-1:0] vin;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      vin = (lfsr[1:0] < 2'd3) ? NV'(1 << lfsr[1:0]) : '0;
      step(vin, lfsr[4:2] | {3{lfsr[7]}}, "R2 R3 R4");
    end
    for (int n = 0; n < 8; n++) step(3'b000, 3'b111, "R8");
    for (int i = 0; i < NV; i++) check("R8 no loss", cnt[i], 0);
    check("R8 drained out_valid", int'(out_valid), 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule